// File: doc/BRIEF.md
# Privileged control register file

This block holds the privileged and hyper-privileged control state of one processor strand. Software reads and writes it through a single port: a 5-bit register number, a write enable and a write word. Reads are combinational and writes land on the clock edge. Some registers shape what they store. The processor-state word keeps only its defined fields. The trap base address drops its low bits. The floating-point register state always reads back with its two dirty bits set.

The per-trap-level stacks hold the saved PC, next PC, state, trap type and hyper-privileged state. They are banked by the current trap level, and an access reaches the entry for level minus one. The block also holds eight scratchpad words and the head and tail pointers of four interrupt and error queues. A write to the trap level can raise a trap-level-zero interrupt request, and the request then holds until the next trap-level write. An access to an unused number, or to a trap stack at an invalid level, raises an error flag and has no effect.

Top module: `pcr_file`

## Requirements
- R1: Register numbers are:
  - 0x00: processor state.
  - 0x01: trap base.
  - 0x02: trap level, stored as 3 bits.
  - 0x03: interrupt level, stored as 4 bits.
  - 0x04: hyper-privileged state.
  - 0x05: strand status.
  - 0x06: floating-point register state.
  - 0x08 to 0x0C: trap PC, trap next PC, trap state, trap type (stored as 9 bits) and hyper-privileged trap state.
  - 0x10 to 0x17: scratchpads.
  - 0x18 to 0x1F: queue pointers.

  All other registers are 64 bits, and narrower registers read back zero-extended.
- R2: After reset the hyper-privileged state reads 0x800, the strand status reads 0x50000, and every other register reads zero. The interrupt request is low.
- R3: A write to the processor state stores the written value ANDed with 0x13DE, which keeps bits 1-4, 6-9 and 12.
- R4: A write to the trap base stores the written value with bits 14:0 cleared.
- R5: A read of the floating-point register state returns the stored value with bits 1:0 forced to one.
- R6: The five trap-stack registers have one entry per trap level from 1 to 6. Each access uses the entry for the current trap level, and entries at other levels are left unchanged.
- R7: An access to a trap-stack register when the trap level is 0 or 7 raises err_o and reads zero. A write in that case changes nothing.
- R8: An access to an unused register number raises err_o and reads zero, and a write to such a number changes no register.
- R9: A trap-level write whose low 3 bits are zero sets tlz_irq_o at the next edge when the hyper-privileged state has bit 0 (trap-level-zero enable) set and bit 2 (hyper-privileged) clear.
- R10: Any other trap-level write clears tlz_irq_o, and writes to other numbers leave it unchanged.
- R11: The eight scratchpads at 0x10+i store and return full 64-bit values independently.
- R12: Queue q (0 = CPU mondo, 1 = device mondo, 2 = resumable error, 3 = non-resumable error) has its head at 0x18+2q and its tail at 0x19+2q.
- R13: rdata_o follows addr_i in the same cycle. A write takes effect at the rising edge, so a read of the register being written shows the old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register number for read and write |
| we_i | input | 1 | Write enable |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for addr_i |
| err_o | output | 1 | Access to an unused number or an invalid trap level |
| tlz_irq_o | output | 1 | Trap-level-zero interrupt request |

## Verification
A corrupted register, such as a dropped write mask or a misbanked trap entry, shows at rdata_o in the same cycle its number is next presented. The bench keeps its own model and compares every register read on every clock. It also sweeps the full map at the end, so a stray write through an unused number or an invalid level is caught. A wrong interrupt rule shows on tlz_irq_o one edge after the trap-level write that caused it.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int AW = 5;
  typedef logic [AW-1:0] rnum_t;

  localparam rnum_t RN_PSTATE  = 5'h00;
  localparam rnum_t RN_TBA     = 5'h01;
  localparam rnum_t RN_TL      = 5'h02;
  localparam rnum_t RN_PIL     = 5'h03;
  localparam rnum_t RN_HPSTATE = 5'h04;
  localparam rnum_t RN_STRAND  = 5'h05;
  localparam rnum_t RN_FPRS    = 5'h06;
  localparam rnum_t RN_TPC     = 5'h08;
  localparam rnum_t RN_TNPC    = 5'h09;
  localparam rnum_t RN_TSTATE  = 5'h0A;
  localparam rnum_t RN_TTYPE   = 5'h0B;
  localparam rnum_t RN_HTSTATE = 5'h0C;
  localparam int    SCR_BASE   = 16;

  localparam int TLW  = 3;
  localparam int PILW = 4;
  localparam int TTW  = 9;

  localparam int HP_TLZ_BIT   = 0;
  localparam int HP_PRIV_BIT  = 2;
  localparam int HP_RESET_BIT = 11;

  localparam logic [63:0] PSTATE_KEEP = 64'h0000_0000_0000_13DE;
  localparam int          TBA_ZBITS   = 15;
  localparam logic [63:0] STRAND_RST  = 64'h0000_0000_0005_0000;

  typedef enum logic [2:0] {
    TS_PC, TS_NPC, TS_STATE, TS_TYPE, TS_HSTATE, TS_NONE
  } ts_sel_e;
endpackage

// File: rtl/pcr_ctrl_regs.sv
module pcr_ctrl_regs
  import pcr_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  rnum_t          addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           hit_o,
  output logic [TLW-1:0] tl_o,
  output logic           tlz_irq_o
);
  localparam logic [DW-1:0] KEEP     = DW'(PSTATE_KEEP);
  localparam logic [DW-1:0] TBA_MASK = {DW{1'b1}} << TBA_ZBITS;
  localparam logic [DW-1:0] HP_RST   = DW'(1) << HP_RESET_BIT;
  localparam logic [DW-1:0] ST_RST   = DW'(STRAND_RST);

  logic [DW-1:0]   pstate_q, tba_q, hpstate_q, strand_q, fprs_q;
  logic [TLW-1:0]  tl_q;
  logic [PILW-1:0] pil_q;
  logic            irq_q;
  logic            tl_wr;

  assign tl_wr = we_i && (addr_i == RN_TL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pstate_q  <= '0;
      tba_q     <= '0;
      tl_q      <= '0;
      pil_q     <= '0;
      hpstate_q <= HP_RST;
      strand_q  <= ST_RST;
      fprs_q    <= '0;
    end else if (we_i) begin
      case (addr_i)
        RN_PSTATE:  pstate_q  <= wdata_i & KEEP;
        RN_TBA:     tba_q     <= wdata_i & TBA_MASK;
        RN_TL:      tl_q      <= wdata_i[TLW-1:0];
        RN_PIL:     pil_q     <= wdata_i[PILW-1:0];
        RN_HPSTATE: hpstate_q <= wdata_i;
        RN_STRAND:  strand_q  <= wdata_i;
        RN_FPRS:    fprs_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  // request follows the enable bits held at the time of the trap-level write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else if (tl_wr)
      irq_q <= (wdata_i[TLW-1:0] == '0) && hpstate_q[HP_TLZ_BIT] && !hpstate_q[HP_PRIV_BIT];
  end

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '0;
    case (addr_i)
      RN_PSTATE:  rdata_o = pstate_q;
      RN_TBA:     rdata_o = tba_q;
      RN_TL:      rdata_o = DW'(tl_q);
      RN_PIL:     rdata_o = DW'(pil_q);
      RN_HPSTATE: rdata_o = hpstate_q;
      RN_STRAND:  rdata_o = strand_q;
      RN_FPRS:    rdata_o = fprs_q | DW'(3);
      default:    hit_o   = 1'b0;
    endcase
  end

  assign tl_o      = tl_q;
  assign tlz_irq_o = irq_q;

  p_pstate_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RN_PSTATE) |=> (pstate_q == ($past(wdata_i) & KEEP)));
  p_tba_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RN_TBA) |=> (tba_q[TBA_ZBITS-1:0] == '0) &&
      (tba_q[DW-1:TBA_ZBITS] == $past(wdata_i[DW-1:TBA_ZBITS])));
  p_fprs_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == RN_FPRS) |-> (rdata_o[1:0] == 2'b11));
  p_tlz_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tlz_irq_o) |-> $past(tl_wr));
  p_tlz_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tl_wr && wdata_i[TLW-1:0] != '0) |=> !tlz_irq_o);
  p_tlz_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tl_wr |=> $stable(tlz_irq_o));
endmodule

// File: rtl/pcr_trap_stack.sv
module pcr_trap_stack
  import pcr_pkg::*;
#(
  parameter int DW     = 64,
  parameter int MAX_TL = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  rnum_t          addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [TLW-1:0] tl_i,
  output logic [DW-1:0]  rdata_o,
  output logic           hit_o,
  output logic           lvl_err_o
);
  localparam int IW = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;

  ts_sel_e        sel;
  logic           lvl_ok;
  logic [IW-1:0]  idx;
  logic [DW-1:0]  pc_q  [MAX_TL];
  logic [DW-1:0]  npc_q [MAX_TL];
  logic [DW-1:0]  st_q  [MAX_TL];
  logic [DW-1:0]  hst_q [MAX_TL];
  logic [TTW-1:0] tt_q  [MAX_TL];

  always_comb begin
    case (addr_i)
      RN_TPC:     sel = TS_PC;
      RN_TNPC:    sel = TS_NPC;
      RN_TSTATE:  sel = TS_STATE;
      RN_TTYPE:   sel = TS_TYPE;
      RN_HTSTATE: sel = TS_HSTATE;
      default:    sel = TS_NONE;
    endcase
  end

  assign hit_o     = (sel != TS_NONE);
  assign lvl_ok    = (tl_i != '0) && (int'(tl_i) <= MAX_TL);
  assign lvl_err_o = hit_o && !lvl_ok;
  assign idx       = IW'(tl_i - TLW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < MAX_TL; l++) begin
        pc_q[l]  <= '0;
        npc_q[l] <= '0;
        st_q[l]  <= '0;
        hst_q[l] <= '0;
        tt_q[l]  <= '0;
      end
    end else if (we_i && lvl_ok) begin
      case (sel)
        TS_PC:     pc_q[idx]  <= wdata_i;
        TS_NPC:    npc_q[idx] <= wdata_i;
        TS_STATE:  st_q[idx]  <= wdata_i;
        TS_TYPE:   tt_q[idx]  <= wdata_i[TTW-1:0];
        TS_HSTATE: hst_q[idx] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (lvl_ok) begin
      case (sel)
        TS_PC:     rdata_o = pc_q[idx];
        TS_NPC:    rdata_o = npc_q[idx];
        TS_STATE:  rdata_o = st_q[idx];
        TS_TYPE:   rdata_o = DW'(tt_q[idx]);
        TS_HSTATE: rdata_o = hst_q[idx];
        default:   rdata_o = '0;
      endcase
    end
  end

  p_stack_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == TS_PC && lvl_ok) |=> (pc_q[$past(idx)] == $past(wdata_i)));
  p_stack_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_err_o |-> (rdata_o == '0));
endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
  import pcr_pkg::*;
#(
  parameter int DW   = 64,
  parameter int N    = 8,
  parameter int BASE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  rnum_t         addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          hit_o
);
  localparam int OW = (N > 1) ? $clog2(N) : 1;

  logic [OW-1:0] off;
  logic [DW-1:0] ent [N];

  assign hit_o = (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + N);
  assign off   = OW'(addr_i - AW'(BASE));

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && hit_o && off == OW'(i)) q <= wdata_i;
    end
    assign ent[i] = q;
  end

  assign rdata_o = hit_o ? ent[off] : '0;

  // serves scratchpads (R11) and queue pointers (R12)
  p_bank_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_o) |=> (ent[$past(off)] == $past(wdata_i)));
endmodule

// File: rtl/pcr_file.sv
module pcr_file
  import pcr_pkg::*;
#(
  parameter int DW     = 64,
  parameter int MAX_TL = 6,
  parameter int N_SCR  = 8,
  parameter int N_QUE  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          tlz_irq_o
);
  localparam int N_QPTR   = 2 * N_QUE;
  localparam int QUE_BASE = SCR_BASE + N_SCR;

  logic [DW-1:0]  c_rd, s_rd, sc_rd, q_rd;
  logic           c_hit, s_hit, sc_hit, q_hit, s_lvl_err;
  logic [TLW-1:0] tl;

  pcr_ctrl_regs #(.DW(DW)) i_ctrl (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .rdata_o(c_rd), .hit_o(c_hit), .tl_o(tl), .tlz_irq_o
  );

  pcr_trap_stack #(.DW(DW), .MAX_TL(MAX_TL)) i_stack (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .tl_i(tl),
    .rdata_o(s_rd), .hit_o(s_hit), .lvl_err_o(s_lvl_err)
  );

  pcr_bank #(.DW(DW), .N(N_SCR), .BASE(SCR_BASE)) i_scratch (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .rdata_o(sc_rd), .hit_o(sc_hit)
  );

  pcr_bank #(.DW(DW), .N(N_QPTR), .BASE(QUE_BASE)) i_queue (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .rdata_o(q_rd), .hit_o(q_hit)
  );

  assign err_o   = !(c_hit || s_hit || sc_hit || q_hit) || s_lvl_err;
  assign rdata_o = err_o ? '0 : (c_rd | s_rd | sc_rd | q_rd);

  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  p_one_owner_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({c_hit, s_hit, sc_hit, q_hit}) <= 1);
endmodule

// File: tb/test_pcr_file.sv
module test_pcr_file;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        err, irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pcr_file i_pcr_file (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .tlz_irq_o(irq)
  );

  // behavioural reference state
  logic [63:0] m_pstate, m_tba, m_hp, m_strand, m_fprs;
  logic [2:0]  m_tl;
  logic [3:0]  m_pil;
  logic        m_irq;
  logic [63:0] m_tpc [6], m_tnpc [6], m_tst [6], m_htst [6], m_tt [6];
  logic [63:0] m_scr [8], m_q [8];

  task automatic m_reset();
    m_pstate = 0; m_tba = 0; m_tl = 0; m_pil = 0; m_fprs = 0;
    m_hp = 64'h800; m_strand = 64'h50000; m_irq = 0;
    for (int i = 0; i < 6; i++) begin
      m_tpc[i] = 0; m_tnpc[i] = 0; m_tst[i] = 0; m_htst[i] = 0; m_tt[i] = 0;
    end
    for (int i = 0; i < 8; i++) begin m_scr[i] = 0; m_q[i] = 0; end
  endtask

  task automatic m_read(input logic [4:0] a, output logic [63:0] d, output logic e);
    int k;
    d = 0; e = 0;
    k = int'(m_tl) - 1;
    if (a >= 5'h08 && a <= 5'h0C && (m_tl == 0 || m_tl > 6)) begin
      e = 1;
    end else if (a >= 5'h10 && a <= 5'h17) begin
      d = m_scr[a - 5'h10];
    end else if (a >= 5'h18) begin
      d = m_q[a - 5'h18];
    end else begin
      case (a)
        5'h00: d = m_pstate;
        5'h01: d = m_tba;
        5'h02: d = {61'b0, m_tl};
        5'h03: d = {60'b0, m_pil};
        5'h04: d = m_hp;
        5'h05: d = m_strand;
        5'h06: d = m_fprs | 64'h3;
        5'h08: d = m_tpc[k];
        5'h09: d = m_tnpc[k];
        5'h0A: d = m_tst[k];
        5'h0B: d = m_tt[k];
        5'h0C: d = m_htst[k];
        default: e = 1;
      endcase
    end
  endtask

  task automatic m_write(input logic [4:0] a, input logic [63:0] w);
    logic [63:0] dd;
    logic ee;
    int k;
    m_read(a, dd, ee);
    k = int'(m_tl) - 1;
    if (!ee) begin
      if (a >= 5'h10 && a <= 5'h17) m_scr[a - 5'h10] = w;
      else if (a >= 5'h18) m_q[a - 5'h18] = w;
      else begin
        case (a)
          5'h00: m_pstate = w & 64'h13DE;
          5'h01: m_tba = {w[63:15], 15'b0};
          5'h02: begin
            m_tl = w[2:0];
            m_irq = (w[2:0] == 0) && m_hp[0] && !m_hp[2];
          end
          5'h03: m_pil = w[3:0];
          5'h04: m_hp = w;
          5'h05: m_strand = w;
          5'h06: m_fprs = w;
          5'h08: m_tpc[k] = w;
          5'h09: m_tnpc[k] = w;
          5'h0A: m_tst[k] = w;
          5'h0B: m_tt[k] = {55'b0, w[8:0]};
          5'h0C: m_htst[k] = w;
          default: ;
        endcase
      end
    end
  endtask

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: drive at the falling edge, compare, then the rising edge commits the write
  task automatic op(input string tag, input logic [4:0] a, input logic w, input logic [63:0] d);
    logic [63:0] ed;
    logic ee;
    @(negedge clk);
    addr = a; we = w; wdata = d;
    #1;
    m_read(a, ed, ee);
    check(tag, "rdata", rdata, ed);
    check(tag, "err", {63'b0, err}, {63'b0, ee});
    check(tag, "irq", {63'b0, irq}, {63'b0, m_irq});
    if (w) m_write(a, d);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 32; a++) op(tag, 5'(a), 1'b0, 64'h0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R2: reset state across the whole map
    sweep("R2");

    // R3 processor state mask, R4 trap base low bits
    op("R3", 5'h00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R3", 5'h00, 1'b1, 64'h0000_0000_0000_2C21);
    op("R3", 5'h00, 1'b0, 0);
    op("R4", 5'h01, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R4", 5'h01, 1'b1, 64'h1234_5678_9ABC_DEF0);
    op("R4", 5'h01, 1'b0, 0);

    // R5 floating-point state read forces low bits
    op("R5", 5'h06, 1'b1, 64'h4);
    op("R5", 5'h06, 1'b1, 64'h0);
    op("R5", 5'h06, 1'b0, 0);

    // R7 trap stack at level 0: error, write dropped
    op("R7", 5'h08, 1'b1, 64'hDEAD);
    op("R7", 5'h0B, 1'b0, 0);
    op("R7", 5'h02, 1'b1, 64'h1);
    op("R7", 5'h08, 1'b0, 0);

    // R6 banking by level
    for (int l = 1; l <= 6; l++) begin
      op("R6", 5'h02, 1'b1, 64'(l));
      op("R6", 5'h08, 1'b1, 64'hA000_0000_0000_0000 | 64'(l));
      op("R6", 5'h09, 1'b1, 64'hB000_0000_0000_0000 | 64'(l));
      op("R6", 5'h0A, 1'b1, 64'hC000_0000_0000_0000 | 64'(l));
      op("R6", 5'h0B, 1'b1, 64'hFFFF_0000_0000_0100 | 64'(l));
      op("R6", 5'h0C, 1'b1, 64'hE000_0000_0000_0000 | 64'(l));
    end
    for (int l = 6; l >= 1; l--) begin
      op("R6", 5'h02, 1'b1, 64'(l));
      for (int a = 8; a <= 12; a++) op("R6", 5'(a), 1'b0, 0);
    end

    // R7 level 7 is out of range
    op("R7", 5'h02, 1'b1, 64'h7);
    op("R7", 5'h0C, 1'b1, 64'h5555);
    op("R7", 5'h0C, 1'b0, 0);

    // R8 unused numbers
    op("R8", 5'h07, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R8", 5'h0D, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R8", 5'h0E, 1'b1, 64'h1);
    op("R8", 5'h0F, 1'b1, 64'h2);
    sweep("R8");

    // R9 / R10 trap-level-zero request
    op("R9", 5'h04, 1'b1, 64'h1);
    op("R9", 5'h02, 1'b1, 64'h0);
    op("R9", 5'h03, 1'b1, 64'hF);
    op("R10", 5'h10, 1'b1, 64'h99);
    op("R10", 5'h02, 1'b1, 64'h3);
    op("R10", 5'h02, 1'b1, 64'h0);
    op("R10", 5'h04, 1'b1, 64'h5);
    op("R10", 5'h02, 1'b1, 64'h0);
    op("R10", 5'h04, 1'b1, 64'h1);
    op("R10", 5'h02, 1'b1, 64'h8);
    op("R10", 5'h02, 1'b1, 64'h2);
    op("R10", 5'h00, 1'b0, 0);

    // R11 scratchpads, R12 queue pointers
    for (int i = 0; i < 8; i++) op("R11", 5'(16 + i), 1'b1, {32'hC0DE_0000, 32'(i * 7 + 1)});
    for (int i = 0; i < 8; i++) op("R11", 5'(16 + i), 1'b0, 0);
    for (int q = 0; q < 4; q++) begin
      op("R12", 5'(24 + 2 * q), 1'b1, 64'h1000 * 64'(q + 1));
      op("R12", 5'(25 + 2 * q), 1'b1, 64'h1000 * 64'(q + 1) + 64'h40);
    end
    for (int a = 24; a < 32; a++) op("R12", 5'(a), 1'b0, 0);

    // R13 read of the register being written shows the old value
    op("R13", 5'h05, 1'b1, 64'hAAAA_5555_AAAA_5555);
    op("R13", 5'h05, 1'b1, 64'h0123_4567_89AB_CDEF);
    op("R13", 5'h05, 1'b0, 0);

    // R1 mixed traffic across the whole map
    for (int n = 0; n < 3000; n++) begin
      logic [4:0]  ra;
      logic [63:0] rd;
      ra = 5'($urandom_range(0, 31));
      rd = {$urandom, $urandom};
      if (ra == 5'h02 && ($urandom_range(0, 3) == 0)) rd[2:0] = 3'b000;
      if (ra == 5'h04 && ($urandom_range(0, 1) == 0)) rd[2:0] = 3'b001;
      op("R1", ra, 1'($urandom_range(0, 1)), rd);
    end
    sweep("R1");

    @(negedge clk);
    we = 1'b0;
    summary();
  end
endmodule